// File: doc/BRIEF.md
# Bridge Overcurrent and Fault Supervisor

This block supervises the two power bridges of a motor driver in digital form. For each bridge it receives two sensed-current codes, one for each high-side switch. It adds the two codes and compares the sum against a per-bridge limit. A short-excursion filter turns the comparison into a per-bridge fault flag, which is active low in the manner of an open-drain pull-down. Once the flag is raised, a per-bridge sequencer leaves the bridge running for a programmable delay. It then forces the bridge off for a programmable disable time and retries.

A die-temperature code and a supply-voltage code each pass through a comparator with separate set and clear thresholds. An over-temperature condition or a low-supply lockout holds every bridge off and abandons any retry sequence in progress. Over-temperature also pulls every fault flag low. A link input ties the bridges together, so that a fault flag on any bridge starts the cutoff sequence on all of them. All thresholds and timings arrive as register inputs, and the block runs in a single clock domain.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: The overcurrent condition of a bridge is true when the sum of its two switch current codes is greater than or equal to the bridge's limit code; neither switch code alone is compared.
- R2: A limit code of 0 selects the parameter DEFAULT_LIMIT (default 1120) as the bridge's limit.
- R3: The fault flag of a bridge rises FLAG_ON_CYC+1 clock edges after the overcurrent condition starts and falls FLAG_OFF_CYC+1 edges after it ends; an excursion shorter than that does not reach the flag.
- R4: `fault_n[i]` is low (active) while the flag of bridge i is set or over-temperature is active, and high otherwise.
- R5: After the fault flag is seen low on `fault_n`, the bridge stays on and `bridge_off` rises delay_cyc+2 edges later.
- R6: `bridge_off` stays high for disable_cyc+1 cycles, then the bridge retries (off low); if the flag is still set, the bridge turns off again delay_cyc+3 edges after the retry.
- R7: With `link_en` high, a fault flag on any bridge starts the cutoff sequence on every bridge; with `link_en` low, the other bridges are unaffected; `fault_n` always reflects only the bridge's own flag.
- R8: Over-temperature sets when temp_code >= temp_trip and clears only when temp_code <= temp_clear; while it is set, all `bridge_off` are high and all `fault_n` are low.
- R9: Undervoltage lockout is active out of reset, clears when vsup_code >= vsup_good and sets again when vsup_code <= vsup_low; while it is active, all `bridge_off` are high and `fault_n` is not affected.
- R10: A thermal or supply hold abandons any cutoff sequence; one edge after the hold clears, the bridges are on.
- R11: During and right after reset, `fault_n` is all ones and `bridge_off` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw1_cur | input | N_BRIDGE*CUR_W | First high-side switch current code, one field per bridge |
| sw2_cur | input | N_BRIDGE*CUR_W | Second high-side switch current code, one field per bridge |
| limit_code | input | N_BRIDGE*(CUR_W+1) | Overcurrent limit per bridge; 0 selects the default |
| temp_code | input | TEMP_W | Die temperature code |
| temp_trip | input | TEMP_W | Over-temperature set threshold |
| temp_clear | input | TEMP_W | Over-temperature clear threshold |
| vsup_code | input | VOLT_W | Supply voltage code |
| vsup_good | input | VOLT_W | Lockout release threshold |
| vsup_low | input | VOLT_W | Lockout engage threshold |
| delay_cyc | input | TIME_W | Cycles from fault detection to bridge cutoff |
| disable_cyc | input | TIME_W | Cycles the bridge is held off |
| link_en | input | 1 | Share overcurrent cutoff across all bridges |
| fault_n | output | N_BRIDGE | Active-low fault flag per bridge |
| bridge_off | output | N_BRIDGE | Bridge disable per bridge, 1 = all switches off |

## Verification
On every cycle, the assertions check the sequencer's transitions: from run into delay when a trigger arrives, and from disabled into retry when the count expires. They also check the forced return to run under a hold, that both hysteresis comparators set and clear on their own thresholds, and that the fault flag changes only towards the registered comparison. The length of each phase, as seen at the ports, only the bench's scenarios can show. The same holds for the rejection of short excursions, for the sum-versus-single-switch comparison at the exact limit and its default, and for the link mode reaching the other bridge.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_DELAY    = 2'd1,
      ST_DISABLED = 2'd2,
      ST_RETRY    = 2'd3
   } bfs_state_t;
endpackage

// File: rtl/bfs_oc_detect.sv
module bfs_oc_detect #(
   parameter int CUR_W         = 10,
   parameter int DEFAULT_LIMIT = 1120,
   parameter int FLAG_ON_CYC   = 10,
   parameter int FLAG_OFF_CYC  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CUR_W-1:0] cur_a,
   input  logic [CUR_W-1:0] cur_b,
   input  logic [CUR_W:0]   limit,
   output logic             flag
);
   localparam int SUM_W  = CUR_W + 1;
   localparam int MAXC   = (FLAG_ON_CYC > FLAG_OFF_CYC) ? FLAG_ON_CYC : FLAG_OFF_CYC;
   localparam int CNT_W  = $clog2(MAXC + 1);

   if (FLAG_ON_CYC < 1 || FLAG_OFF_CYC < 1) begin : g_bad_filter
      $error("filter lengths must be at least 1");
   end
   if (DEFAULT_LIMIT >= (1 << SUM_W)) begin : g_bad_default
      $error("DEFAULT_LIMIT does not fit the sum width");
   end

   logic [SUM_W-1:0] sum, eff_limit;
   logic             oc_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] need;

   // r1_: both switches of the bridge are added before the compare
   assign sum       = {1'b0, cur_a} + {1'b0, cur_b};
   // r2_: zero selects the built-in limit
   assign eff_limit = (limit == '0) ? SUM_W'(DEFAULT_LIMIT) : limit;
   assign need      = flag ? CNT_W'(FLAG_OFF_CYC - 1) : CNT_W'(FLAG_ON_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q <= 1'b0;
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         oc_q <= (sum >= eff_limit);
         if (oc_q != flag) begin
            if (cnt == need) begin
               flag <= oc_q;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end

   // R3: the flag only ever moves toward the registered comparison
   a_r3_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flag) |-> (flag == $past(oc_q)));
endmodule

// File: rtl/bfs_hyst.sv
module bfs_hyst #(
   parameter int W            = 8,
   parameter bit TRIP_HIGH    = 1'b1,
   parameter bit RESET_ACTIVE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] code,
   input  logic [W-1:0] set_thr,
   input  logic [W-1:0] clr_thr,
   output logic         active
);
   logic trip, rel;

   if (TRIP_HIGH) begin : g_high
      assign trip = (code >= set_thr);
      assign rel  = (code <= clr_thr);
   end else begin : g_low
      assign trip = (code <= set_thr);
      assign rel  = (code >= clr_thr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       active <= RESET_ACTIVE;
      else if (trip)    active <= 1'b1;
      else if (rel)     active <= 1'b0;
   end

   // R8 / R9: set on the trip threshold, clear only past the release one
   a_r8_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> active);
   a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip && rel) |=> !active);
endmodule

// File: rtl/bfs_retry_fsm.sv
module bfs_retry_fsm
   import bfs_pkg::*;
#(
   parameter int TIME_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              hold,
   input  logic [TIME_W-1:0] delay_cyc,
   input  logic [TIME_W-1:0] disable_cyc,
   output logic              off
);
   bfs_state_t        st;
   logic [TIME_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RUN;
         cnt <= '0;
      end else if (hold) begin
         st  <= ST_RUN;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_RUN: if (trig) begin
               st  <= ST_DELAY;
               cnt <= delay_cyc;
            end
            ST_DELAY: if (cnt == '0) begin
               st  <= ST_DISABLED;
               cnt <= disable_cyc;
            end else begin
               cnt <= cnt - 1'b1;
            end
            ST_DISABLED: if (cnt == '0) begin
               st <= ST_RETRY;
            end else begin
               cnt <= cnt - 1'b1;
            end
            ST_RETRY: st <= ST_RUN;
            default:  st <= ST_RUN;
         endcase
      end
   end

   assign off = (st == ST_DISABLED);

   // R5: a trigger in run starts the delay, bridge still on
   a_r5_run_to_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && trig && !hold) |=> (st == ST_DELAY));
   // R6: an expired disable count leads to a retry
   a_r6_disable_to_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DISABLED && cnt == '0 && !hold) |=> (st == ST_RETRY));
   // R10: a hold abandons the sequence
   a_r10_hold_to_run: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (st == ST_RUN));
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
   parameter int N_BRIDGE      = 2,
   parameter int CUR_W         = 10,
   parameter int DEFAULT_LIMIT = 1120,
   parameter int FLAG_ON_CYC   = 10,
   parameter int FLAG_OFF_CYC  = 5,
   parameter int TEMP_W        = 8,
   parameter int VOLT_W        = 8,
   parameter int TIME_W        = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_BRIDGE*CUR_W-1:0]     sw1_cur,
   input  logic [N_BRIDGE*CUR_W-1:0]     sw2_cur,
   input  logic [N_BRIDGE*(CUR_W+1)-1:0] limit_code,
   input  logic [TEMP_W-1:0]             temp_code,
   input  logic [TEMP_W-1:0]             temp_trip,
   input  logic [TEMP_W-1:0]             temp_clear,
   input  logic [VOLT_W-1:0]             vsup_code,
   input  logic [VOLT_W-1:0]             vsup_good,
   input  logic [VOLT_W-1:0]             vsup_low,
   input  logic [TIME_W-1:0]             delay_cyc,
   input  logic [TIME_W-1:0]             disable_cyc,
   input  logic                          link_en,
   output logic [N_BRIDGE-1:0]           fault_n,
   output logic [N_BRIDGE-1:0]           bridge_off
);
   localparam int LIM_W = CUR_W + 1;

   if (N_BRIDGE < 1) begin : g_bad_n
      $error("N_BRIDGE must be at least 1");
   end

   logic [N_BRIDGE-1:0] flag, seq_off, trig;
   logic                therm_act, uv_act, hold;

   bfs_hyst #(.W(TEMP_W), .TRIP_HIGH(1'b1), .RESET_ACTIVE(1'b0)) i_therm (
      .clk(clk), .rst_n(rst_n), .code(temp_code),
      .set_thr(temp_trip), .clr_thr(temp_clear), .active(therm_act));

   bfs_hyst #(.W(VOLT_W), .TRIP_HIGH(1'b0), .RESET_ACTIVE(1'b1)) i_uvlo (
      .clk(clk), .rst_n(rst_n), .code(vsup_code),
      .set_thr(vsup_low), .clr_thr(vsup_good), .active(uv_act));

   assign hold = therm_act | uv_act;

   for (genvar b = 0; b < N_BRIDGE; b++) begin : g_bridge
      bfs_oc_detect #(
         .CUR_W(CUR_W), .DEFAULT_LIMIT(DEFAULT_LIMIT),
         .FLAG_ON_CYC(FLAG_ON_CYC), .FLAG_OFF_CYC(FLAG_OFF_CYC)
      ) i_oc (
         .clk(clk), .rst_n(rst_n),
         .cur_a(sw1_cur[b*CUR_W +: CUR_W]),
         .cur_b(sw2_cur[b*CUR_W +: CUR_W]),
         .limit(limit_code[b*LIM_W +: LIM_W]),
         .flag(flag[b]));

      // r7_: linked bridges share any flag
      assign trig[b] = link_en ? (|flag) : flag[b];

      bfs_retry_fsm #(.TIME_W(TIME_W)) i_seq (
         .clk(clk), .rst_n(rst_n), .trig(trig[b]), .hold(hold),
         .delay_cyc(delay_cyc), .disable_cyc(disable_cyc),
         .off(seq_off[b]));

      assign fault_n[b]    = ~(flag[b] | therm_act);
      assign bridge_off[b] = seq_off[b] | hold;
   end

   // R11: lockout is engaged on the first cycle after reset
   a_r11_reset_locked: assert property (@(posedge clk)
      $rose(rst_n) |-> (&bridge_off));
   // R7: with link mode off, a quiet bridge never follows another's flag
   a_r7_unlinked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_en && !flag[0] && !hold) |=> (trig[0] == flag[0]));
endmodule

// File: tb/test_bridge_fault_supervisor.sv
module test_bridge_fault_supervisor;
   localparam int N = 2, CW = 10, LW = 11, ON = 10, OFF = 5;
   localparam int TD = 20, TDIS = 50;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N*CW-1:0] sw1_cur = '0, sw2_cur = '0;
   logic [N*LW-1:0] limit_code = '0;
   logic [7:0]  temp_code = 8'd25, temp_trip = 8'd165, temp_clear = 8'd150;
   logic [7:0]  vsup_code = 8'd0, vsup_good = 8'd140, vsup_low = 8'd120;
   logic [11:0] delay_cyc = 12'(TD), disable_cyc = 12'(TDIS);
   logic        link_en = 1'b0;
   logic [N-1:0] fault_n, bridge_off;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bridge_fault_supervisor i_bridge_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .sw1_cur(sw1_cur), .sw2_cur(sw2_cur),
      .limit_code(limit_code), .temp_code(temp_code), .temp_trip(temp_trip),
      .temp_clear(temp_clear), .vsup_code(vsup_code), .vsup_good(vsup_good),
      .vsup_low(vsup_low), .delay_cyc(delay_cyc), .disable_cyc(disable_cyc),
      .link_en(link_en), .fault_n(fault_n), .bridge_off(bridge_off));

   // temp, vsup, expected bridge_off, expected fault_n
   localparam int NV = 10;
   localparam logic [7:0] V_T [NV] = '{25, 25, 25, 25, 25, 25, 165, 155, 150, 164};
   localparam logic [7:0] V_V [NV] = '{100, 130, 140, 125, 120, 150, 150, 150, 150, 150};
   localparam logic [1:0] V_O [NV] = '{3, 3, 0, 0, 3, 0, 3, 3, 0, 0};
   localparam logic [1:0] V_F [NV] = '{3, 3, 3, 3, 3, 3, 0, 0, 3, 3};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // count edges until the selected output bit reaches val (sampled at negedge)
   task automatic count_until(input int idx, input bit use_off, input bit val, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (((use_off ? bridge_off[idx] : fault_n[idx]) != val) && n < 2000);
   endtask

   task automatic set_cur(input int b, input int p, input int q);
      sw1_cur[b*CW +: CW] = CW'(p);
      sw2_cur[b*CW +: CW] = CW'(q);
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      limit_code[0 +: LW] = LW'(200);
      limit_code[LW +: LW] = '0;
      cyc(3);
      check("R11 fault_n in reset", fault_n, 3);
      check("R11 bridge_off in reset", bridge_off, 3);
      rst_n = 1'b1;
      cyc(1);
      check("R11 bridge_off after reset", bridge_off, 3);

      // table walk: R8 thermal and R9 supply hysteresis
      for (int i = 0; i < NV; i++) begin
         temp_code = V_T[i];
         vsup_code = V_V[i];
         cyc(3);
         check($sformatf("R8/R9 vector %0d bridge_off", i), bridge_off, V_O[i]);
         check($sformatf("R8/R9 R4 vector %0d fault_n", i), fault_n, V_F[i]);
      end

      // R1: sum one below limit, then at limit
      set_cur(0, 120, 79);
      cyc(30);
      check("R1 sum below limit", fault_n[0], 1);
      set_cur(0, 120, 80);
      count_until(0, 0, 0, n);
      check("R1 R3 flag rise edges", n, ON + 1);
      check("R4 other bridge flag", fault_n[1], 1);
      count_until(0, 1, 1, n);
      check("R5 delay to off", n, TD + 2);
      set_cur(0, 0, 0);
      count_until(0, 1, 0, n);
      check("R6 disable length", n, TDIS + 1);
      cyc(100);
      check("R6 retry stays on", bridge_off[0], 0);

      // R3: short excursion ignored
      set_cur(0, 150, 150);
      cyc(ON - 1);
      set_cur(0, 0, 0);
      cyc(30);
      check("R3 short excursion fault_n", fault_n[0], 1);
      check("R3 short excursion bridge_off", bridge_off[0], 0);

      // R3: flag fall delay
      set_cur(0, 150, 150);
      count_until(0, 0, 0, n);
      set_cur(0, 0, 0);
      count_until(0, 0, 1, n);
      check("R3 flag fall edges", n, OFF + 1);
      cyc(150);

      // R6: persisting overcurrent repeats the cutoff
      set_cur(0, 150, 150);
      count_until(0, 1, 1, n);
      count_until(0, 1, 0, n);
      count_until(0, 1, 1, n);
      check("R6 re-cut after retry", n, TD + 3);
      set_cur(0, 0, 0);
      count_until(0, 1, 0, n);
      cyc(100);

      // R2: default limit on bridge 1
      set_cur(1, 600, 519);
      cyc(30);
      check("R2 below default limit", fault_n[1], 1);
      set_cur(1, 600, 520);
      cyc(ON + 3);
      check("R2 at default limit", fault_n[1], 0);
      set_cur(1, 0, 0);
      cyc(150);

      // R7: unlinked, bridge 1 stays on
      set_cur(0, 150, 150);
      count_until(0, 1, 1, n);
      check("R7 unlinked other bridge", bridge_off[1], 0);
      set_cur(0, 0, 0);
      cyc(150);
      // R7: linked, both cut together
      link_en = 1'b1;
      set_cur(0, 150, 150);
      count_until(0, 1, 1, n);
      check("R7 linked both off", bridge_off, 3);
      check("R7 linked own flag only", fault_n[1], 1);
      set_cur(0, 0, 0);
      cyc(150);
      link_en = 1'b0;

      // R10: hold abandons the sequence
      set_cur(0, 150, 150);
      count_until(0, 1, 1, n);
      temp_code = 8'd170;
      set_cur(0, 0, 0);
      cyc(3);
      check("R8 R10 hold both off", bridge_off, 3);
      check("R8 R4 hold fault_n", fault_n, 0);
      cyc(10);
      temp_code = 8'd140;
      cyc(1);
      check("R10 bridges on after hold", bridge_off, 0);
      cyc(80);
      check("R10 no resumed cutoff", bridge_off, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule